// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency signal. It counts the rising edges of one of two asynchronous inputs over a gate window of fixed length. A host asks for a measurement with a one-cycle start pulse. The host then waits for the done flag and clocks the latched count out one bit at a time on a serial data line, most significant bit first.

Two control bits choose the source. The second input can also serve as a plain logic input. In that case the serial data line carries the synchronised level of that pin rather than a count. Both inputs pass through a two-flop synchroniser and a rising-edge detector before they are counted. The gate length comes from the system clock through a parameter that gives the clock cycles in one millisecond.

Top module: `ifc_gated_counter`

## Requirements
- R1: After reset, done is 0 and, with in2_cnt_mode at 1, sdo is 0.
- R2: A start pulse taken with in2_cnt_mode = 1 and sel_in2 = 0 counts rising edges of if_in1 only. Edges on if_in2 have no effect on the result.
- R3: A start pulse taken with in2_cnt_mode = 1 and sel_in2 = 1 counts rising edges of if_in2 only. Edges on if_in1 have no effect on the result.
- R4: The gate_sel code sampled with start sets the window length: 2'b00 gives 4 ms, 2'b01 gives 8 ms, 2'b10 gives 32 ms and 2'b11 gives 64 ms. One millisecond is TICKS_PER_MS clock cycles. done rises exactly (ms x TICKS_PER_MS) cycles after the clock edge that sampled start.
- R5: The result equals the number of rising edges seen during the window. The count starts from zero for every measurement.
- R6: The count saturates at 2^CNT_W - 1 and never wraps.
- R7: Once done is 1, sdo shows result bit CNT_W-1. Each cycle with shift_en high moves the next lower bit onto sdo. After CNT_W shifts, sdo is 0.
- R8: done falls in the cycle after an accepted start pulse and stays low until the window ends.
- R9: With in2_cnt_mode = 0, sdo follows the level of if_in2 (low gives 0, high gives 1) within three clock cycles. sel_in2 and if_in1 have no effect on sdo.
- R10: With in2_cnt_mode = 0, start is ignored. done and the latched result are kept, and can be read out after in2_cnt_mode returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the time base for the gate |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_in1 | input | 1 | First frequency input (asynchronous) |
| if_in2 | input | 1 | Second frequency input, or a logic input (asynchronous) |
| sel_in2 | input | 1 | Source select: 0 = if_in1, 1 = if_in2 |
| in2_cnt_mode | input | 1 | 1 = if_in2 is a count source, 0 = if_in2 is a logic input |
| gate_sel | input | 2 | Gate length code, sampled with start |
| start | input | 1 | One-cycle request to begin a measurement |
| shift_en | input | 1 | Moves the next result bit onto sdo |
| done | output | 1 | Latched result is valid |
| sdo | output | 1 | Serial result bit, or the logic level of if_in2 in port mode |

## Verification
The assertions assume that start and shift_en are one-cycle synchronous pulses. They also assume that gate_sel, sel_in2 and in2_cnt_mode are stable in the cycle start is sampled, and that the host issues no shift while a window is open. The bench drives every control on the falling edge. It sends no shift pulse until done has been seen. It toggles the frequency inputs only well inside each window, a few cycles after start and more than the synchroniser delay before the window closes, so that an edge near the window boundary cannot change the expected count.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {
    GATE_4MS  = 2'b00,
    GATE_8MS  = 2'b01,
    GATE_32MS = 2'b10,
    GATE_64MS = 2'b11
  } gate_sel_e;

  localparam int unsigned GATE_MS_MAX = 64;

  function automatic int unsigned gate_ms(input logic [1:0] code);
    case (gate_sel_e'(code))
      GATE_4MS:  return 4;
      GATE_8MS:  return 8;
      GATE_32MS: return 32;
      default:   return 64;
    endcase
  endfunction
endpackage

// File: rtl/ifc_sync_edge.sv
module ifc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level = sync_q[STAGES-1];
  assign rise  = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ifc_gate_timer.sv
module ifc_gate_timer
  import ifc_pkg::*;
#(
  parameter int TICKS_PER_MS = 50000,
  parameter int TMR_W        = $clog2(GATE_MS_MAX * TICKS_PER_MS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [1:0]       code,
  output logic             expire,
  output logic [TMR_W-1:0] tmr_val
);
  logic [TMR_W-1:0] tmr_q, tmr_d, load_val;

  always_comb begin
    load_val = TMR_W'(gate_ms(code) * TICKS_PER_MS - 1);
    tmr_d    = tmr_q;
    if (load)
      tmr_d = load_val;
    else if (run && (tmr_q != '0))
      tmr_d = tmr_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  assign expire  = (tmr_q == '0);
  assign tmr_val = tmr_q;
endmodule

// File: rtl/ifc_edge_counter.sv
module ifc_edge_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cnt_nxt = cnt_q;
    if (clr)
      cnt_nxt = '0;
    else if (inc && (cnt_q != CNT_MAX))
      cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ifc_shift_out.sv
module ifc_shift_out #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             shift,
  output logic             msb
);
  logic [CNT_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)
      sh_d = load_val;
    else if (shift)
      sh_d = {sh_q[CNT_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign msb = sh_q[CNT_W-1];
endmodule

// File: rtl/ifc_gated_counter.sv
module ifc_gated_counter
  import ifc_pkg::*;
#(
  parameter int CNT_W        = 20,
  parameter int TICKS_PER_MS = 50000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       if_in1,
  input  logic       if_in2,
  input  logic       sel_in2,
  input  logic       in2_cnt_mode,
  input  logic [1:0] gate_sel,
  input  logic       start,
  input  logic       shift_en,
  output logic       done,
  output logic       sdo
);
  localparam int N_IN  = 2;
  localparam int TMR_W = $clog2(GATE_MS_MAX * TICKS_PER_MS + 1);

  logic [N_IN-1:0]  raw_in, lvl, rise;
  logic             busy_q, busy_d, done_q, done_d, src_q, src_d;
  logic             launch, gate_end, expire, cnt_inc, sh_msb;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [TMR_W-1:0] tmr_val;

  assign raw_in = {if_in2, if_in1};

  for (genvar i = 0; i < N_IN; i++) begin : g_sync
    ifc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (raw_in[i]),
      .level    (lvl[i]),
      .rise     (rise[i])
    );
  end

  assign launch   = start & in2_cnt_mode;
  assign gate_end = busy_q & expire & ~launch;
  assign cnt_inc  = busy_q & (src_q ? rise[1] : rise[0]);

  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    src_d  = src_q;
    if (launch) begin
      busy_d = 1'b1;
      done_d = 1'b0;
      src_d  = sel_in2;
    end else if (gate_end) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      src_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      src_q  <= src_d;
    end
  end

  ifc_gate_timer #(.TICKS_PER_MS(TICKS_PER_MS), .TMR_W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (launch),
    .run     (busy_q),
    .code    (gate_sel),
    .expire  (expire),
    .tmr_val (tmr_val)
  );

  ifc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (launch),
    .inc     (cnt_inc),
    .cnt     (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  ifc_shift_out #(.CNT_W(CNT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gate_end),
    .load_val (cnt_nxt),
    .shift    (shift_en & ~busy_q),
    .msb      (sh_msb)
  );

  assign done = done_q;
  assign sdo  = in2_cnt_mode ? sh_msb : lvl[1];
endmodule

// File: rtl/ifc_gated_counter_chk.sv
module ifc_gated_counter_chk #(
  parameter int CNT_W = 20,
  parameter int TMR_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             in2_cnt_mode,
  input logic             done,
  input logic             busy,
  input logic [CNT_W-1:0] cnt,
  input logic [TMR_W-1:0] tmr
);
  a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start && in2_cnt_mode) |=> !done);

  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !in2_cnt_mode) |=> (done == $past(done)));

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(start && in2_cnt_mode)) |-> (cnt >= $past(cnt)));

  a_r4_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(start && in2_cnt_mode)) |-> (tmr == TMR_W'($past(tmr) - 1'b1)));

  a_r4_done_after_gate: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind ifc_gated_counter ifc_gated_counter_chk #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .in2_cnt_mode (in2_cnt_mode),
  .done         (done),
  .busy         (busy_q),
  .cnt          (cnt_q),
  .tmr          (tmr_val)
);

// File: tb/ifc_gated_counter_bench.sv
`timescale 1ns/1ps
module ifc_gated_counter_bench;
  localparam int CNT_W = 8;
  localparam int TICKS = 10;

  logic clk, rst_n, if_in1, if_in2, sel_in2, in2_cnt_mode, start, shift_en;
  logic [1:0] gate_sel;
  logic done, sdo;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  ifc_gated_counter #(.CNT_W(CNT_W), .TICKS_PER_MS(TICKS)) u_ifc_gated_counter (
    .clk(clk), .rst_n(rst_n), .if_in1(if_in1), .if_in2(if_in2),
    .sel_in2(sel_in2), .in2_cnt_mode(in2_cnt_mode), .gate_sel(gate_sel),
    .start(start), .shift_en(shift_en), .done(done), .sdo(sdo)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int gate_cycles(input logic [1:0] c);
    case (c)
      2'b00: return 4 * TICKS;
      2'b01: return 8 * TICKS;
      2'b10: return 32 * TICKS;
      default: return 64 * TICKS;
    endcase
  endfunction

  // behavioural reference for done
  int m_left;
  bit m_busy, m_done, model_on;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0;
    end else if (start && in2_cnt_mode) begin
      m_busy = 1; m_done = 0; m_left = gate_cycles(gate_sel);
    end else if (m_busy) begin
      m_left = m_left - 1;
      if (m_left == 0) begin m_busy = 0; m_done = 1; end
    end
  end

  always @(negedge clk) begin
    if (model_on && !finished) chk("R4/R8 done timing", int'(done), int'(m_done));
  end

  task automatic pulses1(input int n, input int h);
    repeat (4) @(negedge clk);
    repeat (n) begin
      if_in1 = 1'b1; repeat (h) @(negedge clk);
      if_in1 = 1'b0; repeat (h) @(negedge clk);
    end
  endtask

  task automatic pulses2(input int n, input int h);
    repeat (4) @(negedge clk);
    repeat (n) begin
      if_in2 = 1'b1; repeat (h) @(negedge clk);
      if_in2 = 1'b0; repeat (h) @(negedge clk);
    end
  endtask

  task automatic read_out(input string req, input int exp);
    int v = 0;
    for (int i = 0; i < CNT_W; i++) begin
      v = (v << 1) | int'(sdo);
      shift_en = 1'b1;
      @(negedge clk);
      shift_en = 1'b0;
    end
    chk({req, " R7 serial value"}, v, exp);
    chk("R7 sdo zero after all shifts", int'(sdo), 0);
  endtask

  task automatic measure(input logic [1:0] code, input logic s, input int n1, input int h1,
                         input int n2, input int h2, input int exp, input string req);
    gate_sel = code; sel_in2 = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fork
      pulses1(n1, h1);
      pulses2(n2, h2);
    join
    while (!done) @(negedge clk);
    chk("R7 done seen", int'(done), 1);
    read_out(req, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_on = 0;
    rst_n = 1'b0; if_in1 = 0; if_in2 = 0; sel_in2 = 0; in2_cnt_mode = 1'b1;
    start = 0; shift_en = 0; gate_sel = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 sdo after reset", int'(sdo), 0);
    model_on = 1;

    // R2: input 1 counted, input 2 edges ignored
    measure(2'b01, 1'b0, 4, 3, 7, 3, 4, "R2");
    // R3: input 2 counted, input 1 edges ignored
    measure(2'b01, 1'b1, 9, 2, 6, 3, 6, "R3");
    // R5: fresh count, different pattern, shortest gate
    measure(2'b00, 1'b0, 5, 2, 0, 1, 5, "R5");
    measure(2'b00, 1'b1, 0, 1, 0, 1, 0, "R5 cleared");
    // R4: 32 ms gate timing
    measure(2'b10, 1'b0, 11, 5, 0, 1, 11, "R4");
    // R6: saturation in a 64 ms gate
    measure(2'b11, 1'b0, 300, 1, 0, 1, 255, "R6");

    // leave a known result latched for R10
    measure(2'b01, 1'b0, 0, 1, 0, 1, 0, "R5 zero");
    measure(2'b01, 1'b1, 0, 1, 13, 2, 13, "R3 second");
    gate_sel = 2'b01; sel_in2 = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);

    // R9: port mode, level readout
    in2_cnt_mode = 1'b0; sel_in2 = 1'b1; if_in2 = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 high level", int'(sdo), 1);
    sel_in2 = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 sel ignored", int'(sdo), 1);
    if_in2 = 1'b0; if_in1 = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 low level", int'(sdo), 0);
    if_in1 = 1'b0;

    // R10: start ignored in port mode
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 done kept", int'(done), 1);
    repeat (100) @(negedge clk);
    chk("R10 done kept later", int'(done), 1);
    in2_cnt_mode = 1'b1;
    @(negedge clk);
    read_out("R10", 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule